// File: doc/BRIEF.md
# Two-Device Frame Serial Codec Master

This block is the master end of a synchronous, frame-based serial link to at most two external codec devices. It always drives the serial clock and the frame sync. The serial clock is derived from the master clock by a programmable divider. Every frame holds exactly 128 serial clock cycles. The first 64 bits belong to device 0 and the last 64 bits to device 1. The frame sync is high for one serial cycle: the last bit of each frame, which is the cycle just before bit 0 of the next frame.

A CPU-side register port accesses the block. Software loads one transmit word per device and reads back one receive word per device. Each device has a done flag that reports when its receive word has been refreshed. A transmit word that is not rewritten is sent again in every later frame. A new divider value waits for the next frame boundary before it applies, so no frame runs at a mix of rates.

Top module: `codec_frame_master`

## Requirements
- R1: With divider value N, the serial clock is high for N+1 master cycles and low for N+1 master cycles. The first rising edge comes N+1 master cycles after the clock edge that writes the enable bit.
- R2: A frame lasts 128 serial cycles. The sync output is high during exactly one of them, which is bit 127. The next serial cycle carries bit 0 of the next frame.
- R3: The data and sync outputs change only on the master edge where the serial clock rises. The data input is sampled on the rising edge that ends each bit.
- R4: Bits go out most-significant first. Bits 0..63 of a frame come from transmit word 0 (address 2) and bits 64..127 from transmit word 1 (address 3). Each word is copied into the shifter when its subframe starts.
- R5: A transmit word that software does not rewrite is sent unchanged in every following frame.
- R6: Receive word 0 (address 4) holds input bits 0..63 of the last completed subframe 0, MSB first. Receive word 1 (address 5) holds bits 64..127 of the last completed subframe 1. Each is loaded when the last bit of its subframe is sampled.
- R7: The status register (address 1) has done flag 0 in bit 0 and done flag 1 in bit 1. Each flag is set when its receive word is loaded. Writing 1 to a flag clears it and writing 0 leaves it alone. When a set and a clear happen in the same cycle, the set wins.
- R8: A divider value written while the link runs applies from the rising edge that starts bit 0 of the next frame. Until then the current frame keeps the old period.
- R9: While disabled, the serial clock, sync and data outputs are held low. After an enable, the first serial cycle is a sync cycle that carries no receive data and sets no done flag.
- R10: The control register (address 0) holds N in bits 7:0 and enable in bit 8. The control register and both transmit words read back what was written.
- R11: After reset, the outputs are low, the link is disabled, and the status, transmit and receive registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| ser_clk | output | 1 | Serial clock to the codecs |
| ser_sync | output | 1 | Frame sync, high during bit 127 |
| ser_dout | output | 1 | Serial data to the codecs |
| ser_din | input | 1 | Serial data from the codecs |

## Verification
The bench builds the block with its defaults: 64-bit subframes and an 8-bit divider. It keeps N between 0 and 3 so that dozens of complete frames fit into the run. The smallest divider, N=0, gives a two-cycle serial period. That lets the bench place a status clear write on the exact master edge where a done flag is set, which exercises the set-over-clear rule. Divider changes made in the middle of a frame let the bench measure, edge by edge, that the new period starts only at bit 0.

// File: rtl/codec_frame_master.sv
module codec_frame_master #(
  parameter int SUB_BITS = 64,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [SUB_BITS-1:0] reg_wdata,
  output logic [SUB_BITS-1:0] reg_rdata,
  output logic                ser_clk,
  output logic                ser_sync,
  output logic                ser_dout,
  input  logic                ser_din
);
  localparam int FRAME = 2 * SUB_BITS;
  localparam int BW    = $clog2(FRAME);
  localparam logic [BW-1:0] END0  = BW'(SUB_BITS - 1);
  localparam logic [BW-1:0] START1 = BW'(SUB_BITS);
  localparam logic [BW-1:0] END1  = BW'(FRAME - 1);
  localparam logic [BW-1:0] PRE   = BW'(FRAME - 2);

  logic [DIV_W-1:0]    div_reg, div_act, cnt;
  logic                run, sclk_q, sync_q, dout_q, primed;
  logic [SUB_BITS-1:0] tx0, tx1, rx0, rx1, txsh, rxsh;
  logic [1:0]          done;
  logic [BW-1:0]       bitc;

  wire ctrl_wr = reg_wr && reg_addr == 3'd0;
  wire stat_wr = reg_wr && reg_addr == 3'd1;
  wire tick    = run && cnt == div_act;
  wire rise    = tick && !sclk_q;
  wire [BW-1:0] nxt = (bitc == END1) ? '0 : bitc + 1'b1;
  wire load    = nxt == '0 || nxt == START1;
  wire [SUB_BITS-1:0] txsel = (nxt == '0) ? tx0 : tx1;
  wire [SUB_BITS-1:0] cap   = {rxsh[SUB_BITS-2:0], ser_din};
  wire end0 = rise && primed && bitc == END0;
  wire end1 = rise && primed && bitc == END1;
  wire [1:0] clr = stat_wr ? reg_wdata[1:0] : 2'b00;

  assign ser_clk  = sclk_q;
  assign ser_sync = sync_q;
  assign ser_dout = dout_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = SUB_BITS'({run, div_reg});
      3'd1:    reg_rdata = SUB_BITS'(done);
      3'd2:    reg_rdata = tx0;
      3'd3:    reg_rdata = tx1;
      3'd4:    reg_rdata = rx0;
      3'd5:    reg_rdata = rx1;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_reg <= '0;
      run     <= 1'b0;
      tx0     <= '0;
      tx1     <= '0;
      done    <= 2'b00;
    end else begin
      if (ctrl_wr) begin
        div_reg <= reg_wdata[DIV_W-1:0];
        run     <= reg_wdata[DIV_W];
      end
      if (reg_wr && reg_addr == 3'd2) tx0 <= reg_wdata;
      if (reg_wr && reg_addr == 3'd3) tx1 <= reg_wdata;
      done <= (done & ~clr) | {end1, end0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act <= '0;
      cnt     <= '0;
      sclk_q  <= 1'b0;
      sync_q  <= 1'b0;
      dout_q  <= 1'b0;
      bitc    <= PRE;
      primed  <= 1'b0;
      txsh    <= '0;
      rxsh    <= '0;
      rx0     <= '0;
      rx1     <= '0;
    end else if (!run) begin
      cnt     <= '0;
      sclk_q  <= 1'b0;
      sync_q  <= 1'b0;
      dout_q  <= 1'b0;
      bitc    <= PRE;
      primed  <= 1'b0;
      div_act <= ctrl_wr ? reg_wdata[DIV_W-1:0] : div_reg;
    end else begin
      if (tick) begin
        cnt    <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (rise) begin
        bitc   <= nxt;
        sync_q <= nxt == END1;
        if (primed) rxsh <= cap;
        if (end0) rx0 <= cap;
        if (end1) rx1 <= cap;
        if (load) begin
          dout_q <= txsel[SUB_BITS-1];
          txsh   <= {txsel[SUB_BITS-2:0], 1'b0};
        end else begin
          dout_q <= txsh[SUB_BITS-1];
          txsh   <= {txsh[SUB_BITS-2:0], 1'b0};
        end
        if (nxt == '0) begin
          primed  <= 1'b1;
          div_act <= div_reg;
        end
      end
    end
  end

  // R1
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(sclk_q)) |-> $past(run && cnt == div_act));

  // R2
  sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && sync_q) |=> !sync_q);

  // R3
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_q) |-> ($past(rise) || $past(!run)));

  // R7
  done0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[0]) |-> $past(rise && primed && bitc == END0));

  // R7
  done1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[1]) |-> $past(rise && primed && bitc == END1));

  // R8
  div_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(div_act)) |-> $past(rise && bitc == END1));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sclk_q && !sync_q && !dout_q));
endmodule

// File: tb/tb_codec_frame_master.sv
module tb_codec_frame_master;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        ser_clk, ser_sync, ser_dout;
  logic        ser_din = 1'b0;

  codec_frame_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_clk(ser_clk),
    .ser_sync(ser_sync), .ser_dout(ser_dout), .ser_din(ser_din)
  );

  always #(CLK_P/2) clk = ~clk;

  int unsigned total = 0, fails = 0;
  longint cyc = 0, last_rise = 0, en_cyc = 0;
  int pos = 0, frames = 0;
  int cur_div = 0, pending_div = 0;
  bit fresh = 0, in_frame = 0, en_b = 0;
  logic p_sclk = 0, p_dout = 0, p_sync = 0;
  logic [127:0] fo = '0, last_frame = '0, cf = '0, next_codec = '0;
  event rise_ev;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_frame(input logic [63:0] a, input logic [63:0] b);
    return {a, b};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  always @(posedge clk) begin
    #(CLK_P/4);
    cyc++;
    if (rst_n) begin
      if (ser_clk && !p_sclk) begin
        if (fresh) begin
          chk("R1 first edge delay", 128'(cyc - en_cyc), 128'(cur_div + 1));
          chk("R9 first cycle is sync", 128'(ser_sync), 128'(1));
          pos = 127; in_frame = 0; fresh = 0;
        end else begin
          chk("R1 period", 128'(cyc - last_rise), 128'(2 * (cur_div + 1)));
          pos = (pos == 127) ? 0 : pos + 1;
          chk("R2 sync position", 128'(ser_sync), 128'(pos == 127));
        end
        last_rise = cyc;
        if (pos == 0) begin
          in_frame = 1; cur_div = pending_div; cf = next_codec;
        end
        if (in_frame) begin
          fo[127-pos] = ser_dout;
          if (pos == 127) begin frames++; last_frame = fo; end
        end
        ser_din = cf[127-pos];
        ->rise_ev;
      end else if (en_b) begin
        if (p_sclk && !ser_clk)
          chk("R1 high time", 128'(cyc - last_rise), 128'(cur_div + 1));
        chk("R3 dout held between rises", 128'(ser_dout), 128'(p_dout));
        chk("R3 sync held between rises", 128'(ser_sync), 128'(p_sync));
      end
      p_sclk = ser_clk; p_dout = ser_dout; p_sync = ser_sync;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic enable(input int n);
    cur_div = n; pending_div = n;
    wr(3'd0, 64'h100 | 64'(n));
    en_cyc = cyc; fresh = 1; en_b = 1;
  endtask

  task automatic set_div(input int n);
    pending_div = n;
    wr(3'd0, 64'h100 | 64'(n));
  endtask

  task automatic wait_pos(input int p);
    do @(rise_ev); while (pos != p);
  endtask

  task automatic wait_frames(input int n);
    int t;
    t = frames + n;
    while (frames < t) @(rise_ev);
  endtask

  task automatic check_link(input string ctx, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] v;
    chk({"R4 frame out ", ctx}, last_frame, exp_frame(a, b));
    rd(3'd4, v); chk({"R6 rx0 ", ctx}, 128'(v), 128'(next_codec[127:64]));
    rd(3'd5, v); chk({"R6 rx1 ", ctx}, 128'(v), 128'(next_codec[63:0]));
  endtask

  initial begin
    #(CLK_P * 190000);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [63:0] t0, t1, v;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    chk("R11 sclk low", 128'(ser_clk), 0);
    chk("R11 sync low", 128'(ser_sync), 0);
    chk("R11 dout low", 128'(ser_dout), 0);
    rd(3'd0, v); chk("R11 ctrl zero", 128'(v), 0);
    rd(3'd1, v); chk("R11 status zero", 128'(v), 0);
    rd(3'd2, v); chk("R11 tx0 zero", 128'(v), 0);
    rd(3'd4, v); chk("R11 rx0 zero", 128'(v), 0);
    rd(3'd5, v); chk("R11 rx1 zero", 128'(v), 0);
    rst_n = 1'b1;

    t0 = 64'h8000_0000_0000_0001; t1 = 64'hFFFF_0000_A5A5_5A5A;
    wr(3'd2, t0); wr(3'd3, t1);
    next_codec = {rnd64(), rnd64()};
    rd(3'd2, v); chk("R10 tx0 readback", 128'(v), 128'(t0));
    rd(3'd3, v); chk("R10 tx1 readback", 128'(v), 128'(t1));
    enable(2);
    rd(3'd0, v); chk("R10 ctrl readback", 128'(v), 128'(64'h102));
    wait_frames(3);
    check_link("directed", t0, t1);
    rd(3'd1, v); chk("R7 both flags set", 128'(v), 3);

    wr(3'd1, 64'd1); rd(3'd1, v); chk("R7 clear flag 0 only", 128'(v), 2);
    wr(3'd1, 64'd2); rd(3'd1, v); chk("R7 clear flag 1", 128'(v), 0);

    wait_pos(10); wr(3'd1, 64'd3);
    wait_pos(63); rd(3'd1, v); chk("R7 no flag before bit 63 sampled", 128'(v), 0);
    wait_pos(64); rd(3'd1, v); chk("R7 flag 0 at end of subframe 0", 128'(v), 1);
    wait_pos(0);  rd(3'd1, v); chk("R7 flag 1 at end of subframe 1", 128'(v), 3);

    next_codec = {rnd64(), rnd64()};
    wait_frames(3);
    chk("R5 unchanged tx resent", last_frame, exp_frame(t0, t1));
    check_link("resend", t0, t1);

    for (int i = 0; i < 6; i++) begin
      wait_pos(30);
      set_div(int'($urandom % 4));
      t0 = rnd64(); t1 = rnd64();
      wr(3'd2, t0); wr(3'd3, t1);
      next_codec = {rnd64(), rnd64()};
      wait_frames(3);
      check_link($sformatf("R8 random %0d", i), t0, t1);
    end

    wait_pos(30); set_div(0);
    wait_frames(1);
    wait_pos(20); wr(3'd1, 64'd3);
    wait_pos(63);
    @(negedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 64'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R7 collision lands at bit 64", 128'(pos), 64);
    rd(3'd1, v); chk("R7 set wins over clear", 128'(v), 1);

    en_b = 0;
    wr(3'd0, 64'd1);
    @(negedge clk); @(negedge clk);
    chk("R9 sclk low when disabled", 128'(ser_clk), 0);
    chk("R9 sync low when disabled", 128'(ser_sync), 0);
    chk("R9 dout low when disabled", 128'(ser_dout), 0);
    repeat (20) @(negedge clk);
    chk("R9 sclk stays low", 128'(ser_clk), 0);
    wr(3'd1, 64'd3);
    enable(1);
    wait_pos(127);
    wait_pos(0);
    rd(3'd1, v); chk("R9 sync-only cycle captures nothing", 128'(v), 0);
    wait_frames(2);
    check_link("after re-enable", t0, t1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule